// File: doc/BRIEF.md
# Supervisory Reset Pulse Generator

This block merges three reasons to reset a processor into a single stretched reset. The reasons are a power-fail flag from an external supply comparator, an active-low pushbutton and a timeout request from a watchdog. The power-fail flag arrives already synchronised. The pushbutton is synchronised and debounced inside the block. While any reason is present the reset is held active. Once the last reason goes away, the reset stays active for a fixed minimum hold-off before it is released.

All timing is counted in millisecond ticks. A prescaler divides the system clock to make these ticks, and its ratio is a parameter. The hold-off length and the pushbutton qualification length are also parameters, in milliseconds. The reset is driven on two outputs, one active high and one active low. A third output reports that the processor is running, so a watchdog can start its timing only while the reset is inactive.

Top module: `rst_supervisor`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `cpu_rst`=1. After `rst` falls, the block runs a full hold-off before it releases `cpu_rst`.
- R2: While `pwr_fail`=1, `cpu_rst` is 1 from the cycle after `pwr_fail` is first sampled high.
- R3: After the last cause clears, `cpu_rst` stays 1 for at least HOLD_MS*CLKS_PER_MS cycles and falls within (HOLD_MS+1)*CLKS_PER_MS plus a few cycles of pipeline latency.
- R4: `pb_n` passes through two synchroniser flops. It must be sampled low across DEBOUNCE_MS ticks before `cpu_rst` rises. No reset is seen before (DEBOUNCE_MS-1)*CLKS_PER_MS cycles of low input, and the reset is present by DEBOUNCE_MS*CLKS_PER_MS plus 6 cycles.
- R5: Any high sample of the synchronised `pb_n` during qualification restarts the window. Two low stretches shorter than the window, separated by a brief high, cause no reset.
- R6: The hold-off for a pushbutton reset is measured from the release of `pb_n` to high, not from the press.
- R7: A single-cycle `wdt_expire` pulse sets `cpu_rst`=1 on the next cycle and starts a full hold-off.
- R8: A cause that appears during a hold-off reloads it, so the release is measured from the last cause.
- R9: At all times `cpu_rst_n` is the inverse of `cpu_rst`, and `run_ok` is the inverse of `cpu_rst`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| pwr_fail | input | 1 | Synchronised supply-fail flag, active high |
| pb_n | input | 1 | Raw pushbutton, active low |
| wdt_expire | input | 1 | Watchdog timeout request, active high |
| cpu_rst | output | 1 | Processor reset, active high |
| cpu_rst_n | output | 1 | Processor reset, active low |
| run_ok | output | 1 | High while the reset is inactive |

## Verification
A fault in the hold counter shows at the ports as a release that comes too early or too late. Because the release is quantised to ticks, its timing is checked against a window one millisecond wide, measured from the moment the cause clears. A fault in the debounce counter or its restart logic shows as a pushbutton reset that comes early, comes late, or is triggered by two short presses. This is visible within one qualification window. A lost cause path shows as the reset failing to rise on the cycle after a power-fail or watchdog request.

// File: rtl/rst_supervisor_pkg.sv
package rst_supervisor_pkg;

    typedef enum logic [1:0] {
        HS_RUN   = 2'd0,
        HS_CAUSE = 2'd1,
        HS_HOLD  = 2'd2
    } hold_state_e;

    typedef struct packed {
        logic pwr;
        logic pb;
        logic wdt;
    } cause_t;

    function automatic int unsigned cnt_width(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

    function automatic logic any_cause(input cause_t c);
        return c.pwr | c.pb | c.wdt;
    endfunction

endpackage

// File: rtl/ms_tick_gen.sv
module ms_tick_gen #(
    parameter int unsigned CLKS_PER_MS = 125000
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    import rst_supervisor_pkg::*;

    localparam int unsigned W = cnt_width(CLKS_PER_MS);
    localparam logic [W-1:0] LAST = W'(CLKS_PER_MS - 1);

    logic [W-1:0] div_q;

    always_ff @(posedge clk) begin
        if (rst || div_q == LAST) begin
            div_q <= '0;
        end else begin
            div_q <= div_q + 1'b1;
        end
    end

    assign tick = (div_q == LAST);
endmodule

// File: rtl/pb_qualifier.sv
module pb_qualifier #(
    parameter int unsigned DEBOUNCE_MS = 20
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic pb_n,
    output logic pressed
);
    import rst_supervisor_pkg::*;

    localparam int unsigned W = cnt_width(DEBOUNCE_MS + 1);
    localparam logic [W-1:0] LAST = W'(DEBOUNCE_MS - 1);

    logic         sync1_q;
    logic         sync2_q;
    logic [W-1:0] low_ms_q;
    logic         pressed_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync1_q <= 1'b1;
            sync2_q <= 1'b1;
        end else begin
            sync1_q <= pb_n;
            sync2_q <= sync1_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || sync2_q) begin
            low_ms_q  <= '0;
            pressed_q <= 1'b0;
        end else if (tick && !pressed_q) begin
            if (low_ms_q == LAST) begin
                pressed_q <= 1'b1;
            end else begin
                low_ms_q <= low_ms_q + 1'b1;
            end
        end
    end

    assign pressed = pressed_q;
endmodule

// File: rtl/hold_timer.sv
module hold_timer #(
    parameter int unsigned HOLD_MS = 250
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        tick,
    input  rst_supervisor_pkg::cause_t  cause,
    output logic                        active
);
    import rst_supervisor_pkg::*;

    localparam int unsigned W = cnt_width(HOLD_MS + 1);
    localparam logic [W-1:0] LAST = W'(HOLD_MS);

    hold_state_e  state_q;
    logic [W-1:0] ms_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= HS_HOLD;
            ms_q    <= '0;
        end else if (any_cause(cause)) begin
            state_q <= HS_CAUSE;
            ms_q    <= '0;
        end else if (state_q != HS_RUN) begin
            state_q <= HS_HOLD;
            if (tick) begin
                if (ms_q == LAST) begin
                    state_q <= HS_RUN;
                    ms_q    <= '0;
                end else begin
                    ms_q <= ms_q + 1'b1;
                end
            end
        end
    end

    assign active = (state_q != HS_RUN);
endmodule

// File: rtl/rst_supervisor.sv
module rst_supervisor #(
    parameter int unsigned CLKS_PER_MS = 125000,
    parameter int unsigned HOLD_MS     = 250,
    parameter int unsigned DEBOUNCE_MS = 20
) (
    input  logic clk,
    input  logic rst,
    input  logic pwr_fail,
    input  logic pb_n,
    input  logic wdt_expire,
    output logic cpu_rst,
    output logic cpu_rst_n,
    output logic run_ok
);
    import rst_supervisor_pkg::*;

    logic   ms_tick;
    logic   pb_pressed;
    logic   rst_active;
    cause_t causes;

    ms_tick_gen #(.CLKS_PER_MS(CLKS_PER_MS)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .tick (ms_tick)
    );

    pb_qualifier #(.DEBOUNCE_MS(DEBOUNCE_MS)) u_pb (
        .clk     (clk),
        .rst     (rst),
        .tick    (ms_tick),
        .pb_n    (pb_n),
        .pressed (pb_pressed)
    );

    always_comb begin
        causes.pwr = pwr_fail;
        causes.pb  = pb_pressed;
        causes.wdt = wdt_expire;
    end

    hold_timer #(.HOLD_MS(HOLD_MS)) u_hold (
        .clk    (clk),
        .rst    (rst),
        .tick   (ms_tick),
        .cause  (causes),
        .active (rst_active)
    );

    assign cpu_rst   = rst_active;
    assign cpu_rst_n = ~rst_active;
    assign run_ok    = ~rst_active;
endmodule

// File: rtl/rst_supervisor_chk.sv
module rst_supervisor_chk #(
    parameter int unsigned CLKS_PER_MS = 125000,
    parameter int unsigned HOLD_MS     = 250
) (
    input logic clk,
    input logic rst,
    input logic pwr_fail,
    input logic pb_n,
    input logic wdt_expire,
    input logic pb_pressed,
    input logic cpu_rst
);
    localparam logic [31:0] MIN_HOLD = 32'(HOLD_MS * CLKS_PER_MS);

    logic [31:0] quiet_q;

    always_ff @(posedge clk) begin
        if (rst || pwr_fail || wdt_expire || pb_pressed || !cpu_rst) begin
            quiet_q <= '0;
        end else if (quiet_q != 32'hFFFF_FFFF) begin
            quiet_q <= quiet_q + 1'b1;
        end
    end

    // R2
    pwr_fail_forces_chk: assert property (@(posedge clk) disable iff (rst)
        pwr_fail |=> cpu_rst);

    // R7
    wdt_forces_chk: assert property (@(posedge clk) disable iff (rst)
        wdt_expire |=> cpu_rst);

    // R3
    min_hold_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(cpu_rst) |-> (quiet_q >= MIN_HOLD));

    // R4
    pb_rise_needs_low_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(pb_pressed)) |-> ($past(pb_n, 3) == 1'b0));
endmodule

bind rst_supervisor rst_supervisor_chk #(
    .CLKS_PER_MS (CLKS_PER_MS),
    .HOLD_MS     (HOLD_MS)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .pwr_fail   (pwr_fail),
    .pb_n       (pb_n),
    .wdt_expire (wdt_expire),
    .pb_pressed (pb_pressed),
    .cpu_rst    (cpu_rst)
);

// File: tb/test_rst_supervisor.sv
module test_rst_supervisor;
    localparam int C   = 4;
    localparam int HMS = 250;
    localparam int DMS = 20;
    localparam int HOLD_LO = HMS * C;
    localparam int HOLD_HI = (HMS + 1) * C + 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic pwr_fail = 1'b0;
    logic pb_n = 1'b1;
    logic wdt_expire = 1'b0;
    logic cpu_rst, cpu_rst_n, run_ok;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    rst_supervisor #(.CLKS_PER_MS(C), .HOLD_MS(HMS), .DEBOUNCE_MS(DMS)) i_rst_supervisor (
        .clk(clk), .rst(rst), .pwr_fail(pwr_fail), .pb_n(pb_n),
        .wdt_expire(wdt_expire), .cpu_rst(cpu_rst), .cpu_rst_n(cpu_rst_n), .run_ok(run_ok)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic check_range(input string req, input int act, input int lo, input int hi);
        checks++;
        if (act < lo || act > hi) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d..%0d", req, act, lo, hi);
        end
    endtask

    // R9: complementary outputs
    task automatic check_polarity();
        check("R9 cpu_rst_n", int'(cpu_rst_n), int'(!cpu_rst));
        check("R9 run_ok", int'(run_ok), int'(!cpu_rst));
    endtask

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // counts negedges until cpu_rst is low
    task automatic time_release(output int n);
        n = 0;
        while (cpu_rst && n < 4000) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic t_reset();
        int n;
        @(negedge clk);
        check("R1 cpu_rst in reset", int'(cpu_rst), 1);
        check_polarity();
        rst = 1'b0;
        @(negedge clk);
        check("R1 cpu_rst after reset", int'(cpu_rst), 1);
        time_release(n);
        check_range("R1 power-on hold", n + 1, HOLD_LO, HOLD_HI);
        check_polarity();
    endtask

    task automatic t_pwr_fail();
        int n;
        pwr_fail = 1'b1;
        @(negedge clk);
        check("R2 reset on pwr_fail", int'(cpu_rst), 1);
        cycles(3000);
        check("R2 held during pwr_fail", int'(cpu_rst), 1);
        check_polarity();
        pwr_fail = 1'b0;
        time_release(n);
        check_range("R3 hold after pwr_fail", n, HOLD_LO, HOLD_HI);
    endtask

    task automatic t_pb_press();
        int n;
        pb_n = 1'b0;
        cycles((DMS - 1) * C);
        check("R4 no reset before window", int'(cpu_rst), 0);
        cycles(C + 6);
        check("R4 reset after window", int'(cpu_rst), 1);
        cycles(2000);
        check("R6 held while pressed", int'(cpu_rst), 1);
        pb_n = 1'b1;
        time_release(n);
        check_range("R6 hold from release", n, HOLD_LO, HOLD_HI);
    endtask

    task automatic t_pb_glitch();
        pb_n = 1'b0;
        cycles(15 * C);
        pb_n = 1'b1;
        cycles(3);
        pb_n = 1'b0;
        cycles(15 * C);
        check("R5 restart on high sample", int'(cpu_rst), 0);
        pb_n = 1'b1;
        cycles(10);
        check("R5 no reset after glitchy press", int'(cpu_rst), 0);
    endtask

    task automatic t_wdt();
        int n;
        wdt_expire = 1'b1;
        @(negedge clk);
        wdt_expire = 1'b0;
        check("R7 reset next cycle", int'(cpu_rst), 1);
        check_polarity();
        time_release(n);
        check_range("R7 hold after timeout", n + 1, HOLD_LO, HOLD_HI);
    endtask

    task automatic t_reload();
        int n;
        wdt_expire = 1'b1;
        @(negedge clk);
        wdt_expire = 1'b0;
        cycles(600);
        check("R8 still in hold", int'(cpu_rst), 1);
        wdt_expire = 1'b1;
        @(negedge clk);
        wdt_expire = 1'b0;
        time_release(n);
        check_range("R8 hold from second cause", n + 1, HOLD_LO, HOLD_HI);
        pwr_fail = 1'b1;
        @(negedge clk);
        pwr_fail = 1'b0;
        cycles(500);
        pwr_fail = 1'b1;
        @(negedge clk);
        pwr_fail = 1'b0;
        time_release(n);
        check_range("R8 reload by pwr_fail", n + 1, HOLD_LO, HOLD_HI);
    endtask

    initial begin
        cycles(3);
        t_reset();
        t_pwr_fail();
        t_pb_press();
        t_pb_glitch();
        t_wdt();
        t_reload();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule